// File: doc/BRIEF.md
# Cache ECC Scrub and Line-Retire Controller

This block manages errors in an ECC-protected cache data array. In the background it visits the lines of the array one at a time. It starts one visit each time a programmable tick interval expires. Each visit reads the line and samples the ECC status that the array returns.

A correctable error is repaired by writing the corrected word back to the same line. An uncorrectable error causes the line to be purged and retired:
- A clean line is dropped, so the next fill goes to a different line.
- A modified line is first sent toward memory as a poisoned writeback.

Retired lines are kept in a table that the cache allocator can query combinationally. The table only records deletions while it holds fewer entries than a fixed budget. When the count reaches the budget, a deconfigure flag is raised.

The table and the deconfigure flag can be saved through a record output and reloaded after a restart, so both survive the restart. A repair input clears them. Functional array traffic always has priority over the scrubber.

Top module: `ecc_scrub_ctl`

## Requirements
- R1: The scrubber reads the lines in ascending index order. It reads one line per interval, where the interval is `tick_div`+1 clock cycles. After line LINES-1 it wraps to line 0. With no errors and no functional traffic, consecutive reads are exactly one interval apart.
- R2: While `func_busy` is high, `arr_en` stays low. Once `func_busy` falls, the first scrub read goes to the line that was next in order before the stall. No line is skipped.
- R3: A read that returns `arr_ce`=1 without `arr_ue` causes exactly one write (`arr_en`=1, `arr_we`=1) of `arr_corr_data` to the same line. The line is not retired.
- R4: A read that returns `arr_ue`=1 with `arr_dirty`=0 raises `arr_inval` for one cycle, with that line's index on `arr_inval_addr`. It marks the line deleted and makes no writeback request.
- R5: A read that returns `arr_ue`=1 with `arr_dirty`=1 produces one `wb_valid` pulse. The pulse carries the line index, the data word as read, and `wb_poison`=1. The line is also purged and marked deleted, as in R4.
- R6: A deleted line is never read or written by the scrubber again until it is cleared by repair or by reset.
- R7: `lk_deleted` shows the deleted status of line `lk_idx` in the same cycle, with no clock edge between a change of `lk_idx` and the output.
- R8: Deletions are counted. When the count reaches BUDGET (default 14, with 10 for a smaller variant), `deconf` is set. `deconf` stays set until reset, repair, or a record load.
- R9: When the count is already at BUDGET, a further uncorrectable error is still purged, and is still written back if dirty. It is not recorded as deleted, and the sticky `ovf` bit is set instead.
- R10: `rec_map_out` bit i is 1 exactly when line i is deleted. Reset clears the table, `deconf` and `ovf`. A one-cycle `rec_load` replaces the table with `rec_map_in` and sets `deconf` to `rec_deconf_in` OR (number of ones in `rec_map_in` ≥ BUDGET).
- R11: A one-cycle `repair` pulse clears the table, `deconf` and `ovf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_div | input | DIV_W | Scrub interval minus one, in cycles |
| func_busy | input | 1 | A functional array access is pending; the scrubber yields |
| arr_en | output | 1 | Scrub access to the array |
| arr_we | output | 1 | Access is a write |
| arr_addr | output | IDX_W | Line index of the access |
| arr_wdata | output | DATA_W | Corrected data to write |
| arr_rdata | input | DATA_W | Raw data, valid one cycle after a read |
| arr_corr_data | input | DATA_W | Corrected data from the codec, same timing |
| arr_ce | input | 1 | Correctable error on the last read |
| arr_ue | input | 1 | Uncorrectable error on the last read |
| arr_dirty | input | 1 | Line read was modified |
| arr_inval | output | 1 | Purge pulse |
| arr_inval_addr | output | IDX_W | Line to purge |
| wb_valid | output | 1 | Writeback request pulse |
| wb_addr | output | IDX_W | Line of the writeback |
| wb_data | output | DATA_W | Data of the writeback |
| wb_poison | output | 1 | Data is marked uncorrectable |
| lk_idx | input | IDX_W | Lookup line index |
| lk_deleted | output | 1 | Line `lk_idx` is deleted |
| rec_load | input | 1 | Load the persistent record |
| rec_map_in | input | LINES | Record map to load |
| rec_deconf_in | input | 1 | Record deconfigure bit to load |
| rec_map_out | output | LINES | Current deleted-line map for saving |
| repair | input | 1 | Clear table and flags |
| deconf | output | 1 | Cache marked for deconfiguration |
| ovf | output | 1 | Sticky: an error arrived past the budget |

## Verification
The assertions check the following on every cycle:
- The scan index only holds or steps to its successor.
- No scrub read targets a deleted line.
- A purge always leaves the line recorded, or overflow flagged.
- Each writeback follows a dirty uncorrectable read and carries poison.
- The table only takes a new entry below budget.
- `deconf` and `ovf` hold.

Only the directed scenarios can show the rest:
- The read order, interval and wrap.
- Resuming at the right line after a stall.
- The corrected value reaching the array.
- The budget and overflow sequence over a whole sweep.
- The save, reset and reload round trip.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

  typedef enum logic [1:0] {
    SC_WAIT,
    SC_READ,
    SC_CHECK,
    SC_FIX
  } scan_st_t;

  // successor of a line index with wrap
  function automatic int unsigned wrap_next(input int unsigned cur, input int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/scrub_tick.sv
module scrub_tick #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

endmodule

// File: rtl/del_table.sv
module del_table #(
  parameter int LINES  = 16,
  parameter int BUDGET = 14,
  localparam int IDX_W = $clog2(LINES),
  localparam int CNT_W = $clog2(LINES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic [LINES-1:0] load_map,
  input  logic             load_deconf,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  output logic [LINES-1:0] map,
  output logic             full,
  output logic             deconf
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load_cnt;

  always_comb begin
    load_cnt = '0;
    for (int i = 0; i < LINES; i++) load_cnt = load_cnt + CNT_W'(load_map[i]);
  end

  assign full = (cnt >= CNT_W'(BUDGET));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      map    <= '0;
      cnt    <= '0;
      deconf <= 1'b0;
    end else if (load) begin
      map    <= load_map;
      cnt    <= load_cnt;
      deconf <= load_deconf || (load_cnt >= CNT_W'(BUDGET));
    end else if (set_en) begin
      map[set_idx] <= 1'b1;
      cnt          <= cnt + 1'b1;
      if (cnt + 1'b1 >= CNT_W'(BUDGET)) deconf <= 1'b1;
    end
  end

  // R8
  set_below_budget_chk: assert property (@(posedge clk) disable iff (rst)
    set_en |-> !full);

  // R8
  deconf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (deconf && !clr && !load) |=> deconf);

endmodule

// File: rtl/ecc_scrub_ctl.sv
module ecc_scrub_ctl
  import scrub_pkg::*;
#(
  parameter int LINES  = 16,
  parameter int DATA_W = 32,
  parameter int BUDGET = 14,
  parameter int DIV_W  = 12,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  tick_div,
  input  logic              func_busy,
  output logic              arr_en,
  output logic              arr_we,
  output logic [IDX_W-1:0]  arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  input  logic [DATA_W-1:0] arr_rdata,
  input  logic [DATA_W-1:0] arr_corr_data,
  input  logic              arr_ce,
  input  logic              arr_ue,
  input  logic              arr_dirty,
  output logic              arr_inval,
  output logic [IDX_W-1:0]  arr_inval_addr,
  output logic              wb_valid,
  output logic [IDX_W-1:0]  wb_addr,
  output logic [DATA_W-1:0] wb_data,
  output logic              wb_poison,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic              lk_deleted,
  input  logic              rec_load,
  input  logic [LINES-1:0]  rec_map_in,
  input  logic              rec_deconf_in,
  output logic [LINES-1:0]  rec_map_out,
  input  logic              repair,
  output logic              deconf,
  output logic              ovf
);

  scan_st_t          st;
  logic [IDX_W-1:0]  scan_addr;
  logic [IDX_W-1:0]  addr_nxt;
  logic [DATA_W-1:0] fix_data;
  logic              tick;
  logic [LINES-1:0]  del_map;
  logic              tbl_full;
  logic              set_en;
  logic              cur_deleted;

  scrub_tick #(.DIV_W(DIV_W)) u_tick (
    .clk (clk),
    .rst (rst),
    .div (tick_div),
    .tick(tick)
  );

  del_table #(.LINES(LINES), .BUDGET(BUDGET)) u_tbl (
    .clk        (clk),
    .rst        (rst),
    .clr        (repair),
    .load       (rec_load),
    .load_map   (rec_map_in),
    .load_deconf(rec_deconf_in),
    .set_en     (set_en),
    .set_idx    (scan_addr),
    .map        (del_map),
    .full       (tbl_full),
    .deconf     (deconf)
  );

  assign addr_nxt    = IDX_W'(wrap_next(int'(scan_addr), LINES));
  assign cur_deleted = del_map[scan_addr];
  assign lk_deleted  = del_map[lk_idx];
  assign rec_map_out = del_map;

  // array port: issued in the same cycle so a functional request wins at once
  assign arr_en    = !func_busy && (((st == SC_READ) && !cur_deleted) || (st == SC_FIX));
  assign arr_we    = (st == SC_FIX);
  assign arr_addr  = scan_addr;
  assign arr_wdata = fix_data;

  assign set_en = (st == SC_CHECK) && arr_ue && !tbl_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      st             <= SC_WAIT;
      scan_addr      <= '0;
      fix_data       <= '0;
      arr_inval      <= 1'b0;
      arr_inval_addr <= '0;
      wb_valid       <= 1'b0;
      wb_addr        <= '0;
      wb_data        <= '0;
      wb_poison      <= 1'b0;
      ovf            <= 1'b0;
    end else begin
      arr_inval <= 1'b0;
      wb_valid  <= 1'b0;
      wb_poison <= 1'b0;
      if (repair) ovf <= 1'b0;
      unique case (st)
        SC_WAIT: if (tick) st <= SC_READ;
        SC_READ: begin
          if (cur_deleted) scan_addr <= addr_nxt;
          else if (!func_busy) st <= SC_CHECK;
        end
        SC_CHECK: begin
          if (arr_ue) begin
            arr_inval      <= 1'b1;
            arr_inval_addr <= scan_addr;
            if (arr_dirty) begin
              wb_valid  <= 1'b1;
              wb_addr   <= scan_addr;
              wb_data   <= arr_rdata;
              wb_poison <= 1'b1;
            end
            if (tbl_full && !repair) ovf <= 1'b1;
            scan_addr <= addr_nxt;
            st        <= SC_WAIT;
          end else if (arr_ce) begin
            fix_data <= arr_corr_data;
            st       <= SC_FIX;
          end else begin
            scan_addr <= addr_nxt;
            st        <= SC_WAIT;
          end
        end
        SC_FIX: begin
          if (!func_busy) begin
            scan_addr <= addr_nxt;
            st        <= SC_WAIT;
          end
        end
        default: st <= SC_WAIT;
      endcase
    end
  end

  // R1
  scan_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(scan_addr) |-> (scan_addr == $past(addr_nxt)));

  // R6
  no_deleted_read_chk: assert property (@(posedge clk) disable iff (rst)
    (arr_en && !arr_we) |-> !del_map[arr_addr]);

  // R4
  purge_recorded_chk: assert property (@(posedge clk) disable iff (rst)
    (arr_inval && !$past(repair) && !$past(rec_load)) |-> (del_map[arr_inval_addr] || ovf));

  // R5
  wb_poison_chk: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (wb_poison && $past(arr_ue) && $past(arr_dirty)));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf && !repair) |=> ovf);

endmodule

// File: tb/sim_ecc_scrub_ctl.sv
`timescale 1ns/1ps
module sim_ecc_scrub_ctl;
  localparam int N = 16;
  localparam int IW = 4;
  localparam int DW = 32;

  logic clk = 0, rst = 1;
  logic [11:0] tick_div = 12'd3;
  logic func_busy = 0;
  logic arr_en, arr_we, arr_inval, wb_valid, wb_poison, lk_deleted, deconf, ovf;
  logic [IW-1:0] arr_addr, arr_inval_addr, wb_addr;
  logic [IW-1:0] lk_idx = '0;
  logic [DW-1:0] arr_wdata, wb_data;
  logic [DW-1:0] arr_rdata = '0, arr_corr_data = '0;
  logic arr_ce = 0, arr_ue = 0, arr_dirty = 0;
  logic rec_load = 0, rec_deconf_in = 0, repair = 0;
  logic [N-1:0] rec_map_in = '0, rec_map_out;

  always #2 clk = ~clk;

  ecc_scrub_ctl u0 (
    .clk(clk), .rst(rst), .tick_div(tick_div), .func_busy(func_busy),
    .arr_en(arr_en), .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .arr_rdata(arr_rdata), .arr_corr_data(arr_corr_data), .arr_ce(arr_ce),
    .arr_ue(arr_ue), .arr_dirty(arr_dirty), .arr_inval(arr_inval),
    .arr_inval_addr(arr_inval_addr), .wb_valid(wb_valid), .wb_addr(wb_addr),
    .wb_data(wb_data), .wb_poison(wb_poison), .lk_idx(lk_idx), .lk_deleted(lk_deleted),
    .rec_load(rec_load), .rec_map_in(rec_map_in), .rec_deconf_in(rec_deconf_in),
    .rec_map_out(rec_map_out), .repair(repair), .deconf(deconf), .ovf(ovf)
  );

  // array model: error generations are written by tasks, cleared by the model
  logic [DW-1:0] mem [N];
  logic [DW-1:0] ce_pat [N];
  int ce_gen [N], fix_gen [N], ue_gen [N], pg_gen [N];
  bit dirty_f [N];
  int rd_cnt [N], purge_cnt [N];
  int rd_seq [256], rd_cyc [256];
  int rd_n = 0, wr_n = 0, wb_n = 0, bad_yield = 0, cyc = 0;
  logic [IW-1:0] last_wb_addr;
  logic [DW-1:0] last_wb_data;
  logic last_wb_poison;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      for (int a = 0; a < N; a++) begin
        mem[a]     <= 32'hA5A50000 + a;
        fix_gen[a] <= ce_gen[a];
        pg_gen[a]  <= ue_gen[a];
      end
      arr_ce <= 0; arr_ue <= 0;
    end else begin
      arr_ce <= 0; arr_ue <= 0;
      if (arr_en && func_busy) bad_yield <= bad_yield + 1;
      if (arr_en && !arr_we) begin
        arr_rdata     <= (ce_gen[arr_addr] != fix_gen[arr_addr]) ?
                         (mem[arr_addr] ^ ce_pat[arr_addr]) : mem[arr_addr];
        arr_corr_data <= mem[arr_addr];
        arr_ce        <= (ce_gen[arr_addr] != fix_gen[arr_addr]);
        arr_ue        <= (ue_gen[arr_addr] != pg_gen[arr_addr]);
        arr_dirty     <= dirty_f[arr_addr];
        rd_cnt[arr_addr]   <= rd_cnt[arr_addr] + 1;
        rd_seq[rd_n % 256] <= int'(arr_addr);
        rd_cyc[rd_n % 256] <= cyc;
        rd_n <= rd_n + 1;
      end
      if (arr_en && arr_we) begin
        mem[arr_addr]     <= arr_wdata;
        fix_gen[arr_addr] <= ce_gen[arr_addr];
        wr_n <= wr_n + 1;
      end
      if (arr_inval) begin
        pg_gen[arr_inval_addr]    <= ue_gen[arr_inval_addr];
        purge_cnt[arr_inval_addr] <= purge_cnt[arr_inval_addr] + 1;
      end
      if (wb_valid) begin
        wb_n <= wb_n + 1;
        last_wb_addr <= wb_addr; last_wb_data <= wb_data; last_wb_poison <= wb_poison;
      end
    end
  end

  int total = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic peek(input int i, output bit d);
    lk_idx = IW'(i);
    #0.5;
    d = lk_deleted;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    cyc_wait(3);
    rst = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk(deconf == 0 && ovf == 0, "R10", "flags after reset", {deconf, ovf}, 0);
    chk(rec_map_out == 0, "R10", "map after reset", rec_map_out, 0);
    chk(wb_valid == 0 && arr_inval == 0, "R10", "pulses after reset", {wb_valid, arr_inval}, 0);
  endtask

  task automatic t_walk();  // R1
    int base = rd_n;
    bit ok = 1;
    cyc_wait(90);
    for (int i = 0; i < 18; i++) if (rd_seq[(base + i) % 256] != i % N) ok = 0;
    chk(ok, "R1", "read order with wrap", rd_seq[(base + 16) % 256], 0);
    chk(rd_cyc[(base + 1) % 256] - rd_cyc[base % 256] == 4, "R1", "interval",
        rd_cyc[(base + 1) % 256] - rd_cyc[base % 256], 4);
  endtask

  task automatic t_yield();  // R2
    int n0, last;
    n0 = rd_n; last = rd_seq[(n0 + 255) % 256];
    func_busy = 1;
    cyc_wait(40);
    chk(rd_n == n0 && bad_yield == 0, "R2", "reads while busy", rd_n - n0 + bad_yield, 0);
    func_busy = 0;
    cyc_wait(10);
    chk(rd_seq[n0 % 256] == (last + 1) % N, "R2", "resume line", rd_seq[n0 % 256], (last + 1) % N);
  endtask

  task automatic t_ce();  // R3
    int w0 = wr_n;
    bit d;
    ce_pat[3] = 32'h0000_00FF; ce_gen[3]++;
    cyc_wait(100);
    chk(mem[3] == 32'hA5A50003, "R3", "corrected word", mem[3], 32'hA5A50003);
    chk(wr_n - w0 == 1, "R3", "write count", wr_n - w0, 1);
    peek(3, d);
    chk(d == 0, "R3", "line 3 kept", d, 0);
  endtask

  task automatic t_ue_clean();  // R4
    int p0 = purge_cnt[5], b0 = wb_n;
    bit d;
    dirty_f[5] = 0; ue_gen[5]++;
    cyc_wait(100);
    chk(purge_cnt[5] - p0 == 1, "R4", "purge of line 5", purge_cnt[5] - p0, 1);
    chk(wb_n == b0, "R4", "no writeback", wb_n - b0, 0);
    peek(5, d);
    chk(d == 1, "R4", "line 5 deleted", d, 1);
  endtask

  task automatic t_ue_dirty();  // R5
    int p0 = purge_cnt[7], b0 = wb_n;
    bit d;
    dirty_f[7] = 1; ue_gen[7]++;
    cyc_wait(100);
    chk(wb_n - b0 == 1, "R5", "writeback count", wb_n - b0, 1);
    chk(last_wb_addr == 7 && last_wb_poison == 1, "R5", "wb line/poison",
        {last_wb_addr, last_wb_poison}, {4'd7, 1'b1});
    chk(last_wb_data == 32'hA5A50007, "R5", "wb data", last_wb_data, 32'hA5A50007);
    chk(purge_cnt[7] - p0 == 1, "R5", "purge of line 7", purge_cnt[7] - p0, 1);
    peek(7, d);
    chk(d == 1, "R5", "line 7 deleted", d, 1);
  endtask

  task automatic t_skip();  // R6
    int r5 = rd_cnt[5], r7 = rd_cnt[7], r6 = rd_cnt[6];
    cyc_wait(100);
    chk(rd_cnt[5] == r5 && rd_cnt[7] == r7, "R6", "deleted lines read",
        rd_cnt[5] - r5 + rd_cnt[7] - r7, 0);
    chk(rd_cnt[6] > r6, "R6", "neighbour still read", rd_cnt[6] - r6, 1);
  endtask

  task automatic t_lookup();  // R7
    bit ok = 1;
    bit d;
    for (int i = 0; i < N; i++) begin
      peek(i, d);
      if (d != (i == 5 || i == 7)) ok = 0;
    end
    chk(ok, "R7", "combinational lookup", ok, 1);
    chk(rec_map_out == 16'h00A0, "R10", "saved map", rec_map_out, 16'h00A0);
  endtask

  task automatic t_budget();  // R8
    int lines [12] = '{0, 1, 2, 4, 6, 8, 9, 10, 11, 12, 13, 14};
    foreach (lines[k]) begin dirty_f[lines[k]] = 0; ue_gen[lines[k]]++; end
    cyc_wait(160);
    chk(deconf == 1, "R8", "deconf at budget", deconf, 1);
    chk(rec_map_out == 16'h7FF7, "R8", "map at budget", rec_map_out, 16'h7FF7);
    chk(ovf == 0, "R8", "no overflow yet", ovf, 0);
  endtask

  task automatic t_overflow();  // R9
    int b0 = wb_n, p0 = purge_cnt[15];
    bit d;
    dirty_f[15] = 1; ue_gen[15]++;
    cyc_wait(100);
    chk(ovf == 1, "R9", "overflow set", ovf, 1);
    peek(15, d);
    chk(d == 0, "R9", "line 15 not recorded", d, 0);
    chk(wb_n - b0 == 1 && last_wb_addr == 15 && last_wb_poison, "R9", "writeback past budget",
        last_wb_addr, 15);
    chk(purge_cnt[15] - p0 == 1, "R9", "purge past budget", purge_cnt[15] - p0, 1);
    cyc_wait(40);
    chk(ovf == 1 && deconf == 1, "R9", "flags held", {ovf, deconf}, 3);
  endtask

  task automatic t_record();  // R10
    logic [N-1:0] saved = rec_map_out;
    do_reset();
    chk(rec_map_out == 0 && deconf == 0 && ovf == 0, "R10", "cleared by reset",
        {rec_map_out, deconf, ovf}, 0);
    @(negedge clk); rec_map_in = saved; rec_deconf_in = 0; rec_load = 1;
    @(negedge clk); rec_load = 0;
    chk(rec_map_out == saved, "R10", "map reloaded", rec_map_out, saved);
    chk(deconf == 1, "R10", "deconf from full map", deconf, 1);
  endtask

  task automatic t_repair();  // R11
    bit d;
    @(negedge clk); repair = 1;
    @(negedge clk); repair = 0;
    chk(rec_map_out == 0 && deconf == 0 && ovf == 0, "R11", "repair clears",
        {rec_map_out, deconf, ovf}, 0);
    rec_map_in = 16'h0200; rec_deconf_in = 1; rec_load = 1;
    @(negedge clk); rec_load = 0;
    peek(9, d);
    chk(deconf == 1 && d == 1, "R10", "deconf bit reloaded", {deconf, d}, 3);
    @(negedge clk); repair = 1;
    @(negedge clk); repair = 0;
    chk(deconf == 0, "R11", "second repair", deconf, 0);
  endtask

  initial begin
    t_reset();
    t_walk();
    t_yield();
    t_ce();
    t_ue_clean();
    t_ue_dirty();
    t_skip();
    t_lookup();
    t_budget();
    t_overflow();
    t_record();
    t_repair();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end

  initial begin
    #400000;
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end

endmodule